// File: doc/BRIEF.md
# Cascaded 32-bit Deadline Timer

A free-running 32-bit microsecond time base made of two chained 16-bit halves. A programmable prescaler divides the timer clock into a tick. Each tick advances the low half. When the low half rolls over, it produces an update event that carries one into the high half. When the high half rolls over, a sticky wrap flag is set. Software can load the count at any time. The 32-bit count output always shows both halves as they stood after the same clock edge.

A 32-bit deadline is armed in two stages. At arming, the upper 16 bits of the deadline are compared with the current high half:
- If they are larger, only the high-stage compare is enabled.
- If they are equal, only the low-stage compare is enabled.
- If they are smaller, the deadline is in the past and nothing is enabled.

When the high stage reaches its target, the hardware hands the compare over to the low stage. No match is lost in this hand-off. When the full count equals the deadline, a sticky event flag is raised. A deadline should be later than the count at the arming edge.

Top module: `casc_deadline_timer`

## Requirements
- R1: After reset, `count` is 0, `irq_event` and `wrap_flag` are 0, both compare stages are disabled, and the prescaler reload value is DIV_INIT.
- R2: The low half advances by one once every (active divider + 1) clock cycles. `count` does not change between ticks unless it is written.
- R3: On a tick with the low half at 0xFFFF, the low half becomes 0 and the high half increments on the same edge.
- R4: A divider written on `div_wr` becomes active only at the next low-half update event or at an `upd_gen` strobe. Either of these also reloads the prescaler countdown with the pending value.
- R5: `cnt_wr` loads `cnt_val[31:16]` into the high half and `cnt_val[15:0]` into the low half. It takes priority over counting on that edge.
- R6: Arming with a deadline whose upper half exceeds the current high half enables only the high stage.
- R7: Arming with a deadline whose upper half equals the current high half enables only the low stage.
- R8: Arming clears `irq_event`. A deadline already in the past (upper half below the high half, or equal upper half with the low half already beyond it) never raises the event.
- R9: While armed, `irq_event` rises on the edge after `count` equals the deadline. A high-stage match passes the compare to the low stage automatically.
- R10: A high-half rollover sets `wrap_flag`. `st_clr` clears both flags, but a flag being set on the same edge wins over the clear.
- R11: `ev_off` disables both compare stages on the next edge and takes priority over `dl_wr`. No event follows until the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Write pending prescaler divider |
| div_val | input | DIV_W | Divider value (tick every div_val+1 cycles) |
| upd_gen | input | 1 | Software update strobe: activate divider, reload prescaler |
| cnt_wr | input | 1 | Load the 32-bit count |
| cnt_val | input | 2*HALF_W | Count value to load |
| dl_wr | input | 1 | Arm a deadline |
| dl_val | input | 2*HALF_W | Deadline value |
| ev_off | input | 1 | Disable both compare stages |
| st_clr | input | 1 | Clear event and wrap flags |
| count | output | 2*HALF_W | Current count {high, low} |
| irq_event | output | 1 | Sticky deadline-reached flag |
| wrap_flag | output | 1 | Sticky high-half rollover flag |

## Verification
The assertions check the following on every cycle:
- the stage chosen at arming (R6, R7);
- that the two stages are never enabled together;
- the carry from low to high half (R3);
- the hold between ticks (R2);
- the flag clear on arming (R8);
- the disable (R11);
- the wrap set (R10).

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a model:
- the prescaler period and when a new divider is latched (R4);
- the high-to-low hand-off reaching an exact match across a low rollover (R9);
- past deadlines staying silent.

// File: rtl/casc_deadline_timer.sv
module casc_deadline_timer #(
  parameter int HALF_W   = 16,
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  div_wr,
  input  logic [DIV_W-1:0]      div_val,
  input  logic                  upd_gen,
  input  logic                  cnt_wr,
  input  logic [2*HALF_W-1:0]   cnt_val,
  input  logic                  dl_wr,
  input  logic [2*HALF_W-1:0]   dl_val,
  input  logic                  ev_off,
  input  logic                  st_clr,
  output logic [2*HALF_W-1:0]   count,
  output logic                  irq_event,
  output logic                  wrap_flag
);
  localparam logic [HALF_W-1:0] HMAX = '1;
  localparam logic [DIV_W-1:0]  DINI = DIV_W'(DIV_INIT);

  logic [DIV_W-1:0]  psc_pend, psc_act, psc_cnt;
  logic [HALF_W-1:0] lo_q, hi_q, lo_cmp, hi_cmp;
  logic              lo_en, hi_en;

  wire tick     = (psc_cnt == '0);
  wire lo_roll  = tick && (lo_q == HMAX);
  wire upd_ev   = lo_roll || upd_gen;
  wire carry    = lo_roll && !cnt_wr;
  wire hi_roll  = carry && (hi_q == HMAX);
  wire [HALF_W-1:0] dl_hi = dl_val[2*HALF_W-1:HALF_W];
  wire [HALF_W-1:0] dl_lo = dl_val[HALF_W-1:0];
  wire hi_hit   = hi_en && (hi_q == hi_cmp);
  wire match    = (lo_en || hi_en) && (hi_q == hi_cmp) && (lo_q == lo_cmp);

  assign count = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_pend <= DINI;
      psc_act  <= DINI;
      psc_cnt  <= DINI;
    end else begin
      if (div_wr) psc_pend <= div_val;
      if (upd_ev) begin
        psc_act <= psc_pend;
        psc_cnt <= psc_pend;
      end else if (tick) begin
        psc_cnt <= psc_act;
      end else begin
        psc_cnt <= psc_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cnt_wr) begin
      lo_q <= cnt_val[HALF_W-1:0];
      hi_q <= cnt_val[2*HALF_W-1:HALF_W];
    end else if (tick) begin
      lo_q <= lo_q + 1'b1;
      if (carry) hi_q <= hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_en  <= 1'b0;
      hi_en  <= 1'b0;
      lo_cmp <= '0;
      hi_cmp <= '0;
    end else if (ev_off) begin
      lo_en <= 1'b0;
      hi_en <= 1'b0;
    end else if (dl_wr) begin
      lo_cmp <= dl_lo;
      hi_cmp <= dl_hi;
      hi_en  <= (dl_hi > hi_q);
      lo_en  <= (dl_hi == hi_q);
    end else if (hi_hit) begin
      hi_en <= 1'b0;
      lo_en <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_event <= 1'b0;
      wrap_flag <= 1'b0;
    end else begin
      if (dl_wr)       irq_event <= 1'b0;
      else if (match)  irq_event <= 1'b1;
      else if (st_clr) irq_event <= 1'b0;
      if (hi_roll)     wrap_flag <= 1'b1;
      else if (st_clr) wrap_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/casc_deadline_timer_chk.sv
module casc_deadline_timer_chk #(
  parameter int HALF_W = 16,
  parameter int DIV_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cnt_wr,
  input logic                dl_wr,
  input logic [2*HALF_W-1:0] dl_val,
  input logic                ev_off,
  input logic [DIV_W-1:0]    psc_cnt,
  input logic [HALF_W-1:0]   lo_q,
  input logic [HALF_W-1:0]   hi_q,
  input logic                lo_en,
  input logic                hi_en,
  input logic [2*HALF_W-1:0] count,
  input logic                irq_event,
  input logic                wrap_flag
);
  localparam logic [HALF_W-1:0] HMAX = '1;
  wire ck_tick = (psc_cnt == '0);
  wire [HALF_W-1:0] ck_dh = dl_val[2*HALF_W-1:HALF_W];

  assert_one_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lo_en, hi_en}) <= 1);
  assert_arm_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dl_wr && !ev_off && (ck_dh > hi_q) |=> hi_en && !lo_en);
  assert_arm_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dl_wr && !ev_off && (ck_dh == hi_q) |=> lo_en && !hi_en);
  assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr && ck_tick && lo_q == HMAX |=> lo_q == '0 && hi_q == $past(hi_q) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr && !ck_tick |=> $stable(count));
  assert_arm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dl_wr |=> !irq_event);
  assert_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_off |=> !lo_en && !hi_en);
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr && ck_tick && lo_q == HMAX && hi_q == HMAX |=> wrap_flag);
endmodule

bind casc_deadline_timer casc_deadline_timer_chk #(.HALF_W(HALF_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .dl_wr(dl_wr), .dl_val(dl_val),
  .ev_off(ev_off), .psc_cnt(psc_cnt), .lo_q(lo_q), .hi_q(hi_q), .lo_en(lo_en),
  .hi_en(hi_en), .count(count), .irq_event(irq_event), .wrap_flag(wrap_flag));

// File: tb/test_casc_deadline_timer.sv
module test_casc_deadline_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_INIT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic div_wr = 0, upd_gen = 0, cnt_wr = 0, dl_wr = 0, ev_off = 0, st_clr = 0;
  logic [7:0]  div_val = 0;
  logic [31:0] cnt_val = 0, dl_val = 0;
  logic [31:0] count;
  logic irq_event, wrap_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [7:0]  m_pend, m_act, m_pc;
  logic [31:0] m_cnt, m_dl;
  logic        m_arm, m_ev, m_wrap;

  always #(CLK_PERIOD/2) clk = ~clk;

  casc_deadline_timer #(.HALF_W(16), .DIV_W(8), .DIV_INIT(DIV_INIT)) i_casc_deadline_timer (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val), .upd_gen(upd_gen),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .dl_wr(dl_wr), .dl_val(dl_val),
    .ev_off(ev_off), .st_clr(st_clr), .count(count), .irq_event(irq_event),
    .wrap_flag(wrap_flag));

  function automatic logic will_arm(input logic [31:0] dl, input logic [31:0] now);
    return dl[31:16] >= now[31:16];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = DIV_INIT; m_act = DIV_INIT; m_pc = DIV_INIT;
      m_cnt = 0; m_dl = 0; m_arm = 0; m_ev = 0; m_wrap = 0;
    end else begin
      logic tk, roll, hit, hroll;
      tk    = (m_pc == 0);
      roll  = tk && (m_cnt[15:0] == 16'hFFFF);
      hit   = m_arm && (m_cnt == m_dl);
      hroll = roll && !cnt_wr && (m_cnt[31:16] == 16'hFFFF);
      if (dl_wr) m_ev = 0; else if (hit) m_ev = 1; else if (st_clr) m_ev = 0;
      if (hroll) m_wrap = 1; else if (st_clr) m_wrap = 0;
      if (ev_off) m_arm = 0;
      else if (dl_wr) begin m_arm = will_arm(dl_val, m_cnt); m_dl = dl_val; end
      if (roll || upd_gen) begin m_act = m_pend; m_pc = m_pend; end
      else if (tk) m_pc = m_act;
      else m_pc = m_pc - 1;
      if (div_wr) m_pend = div_val;
      if (cnt_wr) m_cnt = cnt_val;
      else if (tk) m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 R5 count", count, m_cnt);
    chk("R6 R7 R8 R9 R11 irq_event", {31'd0, irq_event}, {31'd0, m_ev});
    chk("R10 wrap_flag", {31'd0, wrap_flag}, {31'd0, m_wrap});
  endtask

  task automatic idle_inputs();
    div_wr = 0; upd_gen = 0; cnt_wr = 0; dl_wr = 0; ev_off = 0; st_clr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 count", count, 32'd0);
    chk("R1 irq_event", {31'd0, irq_event}, 32'd0);
    chk("R1 wrap_flag", {31'd0, wrap_flag}, 32'd0);
    // R2: tick every DIV_INIT+1 cycles
    repeat (20) step();
    chk("R2 count after 21 cycles", count, m_cnt);

    // R4: pending divider not active until update
    div_wr = 1; div_val = 0; step();
    repeat (8) step();
    upd_gen = 1; step();
    repeat (8) step();

    // R5/R3/R10: load near full wrap
    cnt_wr = 1; cnt_val = 32'hFFFF_FFFA; step();
    repeat (12) step();
    chk("R10 wrap set after rollover", {31'd0, wrap_flag}, 32'd1);
    st_clr = 1; step();
    chk("R10 wrap cleared", {31'd0, wrap_flag}, 32'd0);

    // R9: high-stage arm with hand-off across a low rollover, low deadline 2
    cnt_wr = 1; cnt_val = 32'h0010_FFF0; step();
    dl_wr = 1; dl_val = 32'h0011_0002; step();
    repeat (30) step();
    chk("R9 event after hand-off", {31'd0, irq_event}, 32'd1);

    // R8: past deadline, equal upper half with low already beyond
    dl_wr = 1; dl_val = {count[31:16], 16'h0000}; step();
    repeat (20) step();
    chk("R8 past deadline silent", {31'd0, irq_event}, 32'd0);

    // R11: disable before match
    dl_wr = 1; dl_val = count + 32'd10; step();
    ev_off = 1; step();
    repeat (20) step();
    chk("R11 no event after disable", {31'd0, irq_event}, 32'd0);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2) begin div_wr = 1; div_val = 8'($urandom_range(0, 3)); end
      else if (r < 4) upd_gen = 1;
      else if (r < 6) begin
        cnt_wr = 1;
        cnt_val = {($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'($urandom),
                   16'hFFFF - 16'($urandom_range(0, 30))};
      end else if (r < 12) begin
        dl_wr = 1;
        if ($urandom_range(0, 3) == 0) dl_val = m_cnt - 32'($urandom_range(1, 70000));
        else dl_val = m_cnt + 32'($urandom_range(2, 60));
      end else if (r < 13) ev_off = 1;
      else if (r < 15) st_clr = 1;
      step();
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule